// File: doc/BRIEF.md
# Four-Channel DAC Power and Fault Register

This block keeps the power state and the fault state of four DAC output channels. It sits behind a decoded register interface. A write strobe with a register-select code picks this register, and four data bits then set or clear the power-up enables of the channels. A read strobe with the same code captures an 11-bit status word that holds the power-up enables, a thermal shutdown flag and four overcurrent alerts.

Each channel that is switched from off to on enters a settling window of a fixed number of clock cycles. The length comes from a clock-frequency parameter and a window length in microseconds, 10 µs by default. While the window runs, an output-load request for that channel is held back, and it is released as a one-cycle load pulse when the window ends.

Fault inputs act on the enables without any help from software. An overcurrent on a channel latches that channel's alert. If output clamping is off, the overcurrent also switches that channel off. An overtemperature condition switches every channel off and latches the thermal flag. Alerts stay set until the register is read while the matching fault input is low.

Top module: `dac_pwr_fault_reg`

## Requirements
- R1: After reset, `pwr_on` is 0000, `ld_out` is 0000 and `rd_data` is 0.
- R2: A write with `reg_sel` equal to 3'b010 loads `wr_pu` into `pwr_on` (bit 0 is channel A, bit 3 is channel D) on the next clock edge. A write with any other `reg_sel` leaves `pwr_on` unchanged.
- R3: A read with `reg_sel` equal to 3'b010 captures the status word into `rd_data` on the next edge. The word holds the power-up enables in bits 3:0, the thermal flag in bit 5 and the overcurrent alerts for A..D in bits 7..10, with bits 4 and 6 at 0. A read with any other code leaves `rd_data` unchanged and clears nothing.
- R4: When a channel's enable goes from 0 to 1, a settling window of SETTLE_CYC cycles starts. A load request made during the window produces that channel's `ld_out` pulse exactly SETTLE_CYC edges after the enabling write, and never earlier.
- R5: A load request for a channel that is enabled and settled gives a one-cycle `ld_out` pulse on the next edge. A channel that is switched off gets no pulse.
- R6: An overcurrent input with `clamp_en` at 0 clears that channel's enable on the next edge, and it wins over a write that sets the enable in the same cycle.
- R7: An overcurrent input sets that channel's alert whatever the value of `clamp_en`. With `clamp_en` at 1 the enable is kept.
- R8: An asserted `ot_in` clears all four enables and sets the thermal flag. A write that sets enables has no effect while `ot_in` is high.
- R9: Alerts and the thermal flag are sticky. A read returns them and then clears each one whose fault input is low. One whose input is still high stays set.
- R10: A channel that is switched off while a deferred load is pending drops that load, and no pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register-select code. This register answers to 3'b010 |
| wr_pu | input | 4 | Power-up enables written to channels A..D |
| ld_req | input | 1 | Output-load request for all channels |
| clamp_en | input | 1 | 1 = output clamping on (an overcurrent does not switch the channel off) |
| oc_in | input | 4 | Overcurrent flags for channels A..D |
| ot_in | input | 1 | Overtemperature flag |
| pwr_on | output | 4 | Current power-up enables |
| ld_out | output | 4 | Per-channel one-cycle output-load pulses |
| rd_data | output | 11 | Status word captured by the last read |

## Verification
The bench measures the exact distance from an enabling write to a deferred load pulse. A design with an off-by-one window, or one that lets the load through at once, shows the pulse on the wrong edge. It drives an overcurrent together with a write that sets the same channel, and it holds overtemperature while software tries to switch the channels on. A design that gives the write priority would leave those channels powered. It reads alerts while their inputs are still high and again after they fall: clearing on every read would lose a live fault, and never clearing would keep a stale one. A channel is switched off in the middle of its window with a load pending, which finds designs that still let the stale load through.

// File: rtl/dac_pf_pkg.sv
package dac_pf_pkg;
  localparam int          NCH         = 4;
  localparam int          STAT_W      = 11;
  localparam logic [2:0]  PWR_REG_SEL = 3'b010;
  localparam int          TSD_POS     = 5;
  localparam int          OC_LSB      = 7;

  function automatic logic [STAT_W-1:0] pack_status(
    input logic [NCH-1:0] pu,
    input logic           tsd,
    input logic [NCH-1:0] oc
  );
    logic [STAT_W-1:0] w;
    w                      = '0;
    w[NCH-1:0]             = pu;
    w[TSD_POS]             = tsd;
    w[OC_LSB +: NCH]       = oc;
    return w;
  endfunction
endpackage

// File: rtl/pf_reset_sync.sv
module pf_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pf_access_decode.sv
module pf_access_decode
  import dac_pf_pkg::*;
(
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] reg_sel,
  output logic       wr_hit,
  output logic       rd_hit
);
  logic sel_match;

  always_comb begin
    sel_match = (reg_sel == PWR_REG_SEL);
    wr_hit    = wr_en & sel_match;
    rd_hit    = rd_en & sel_match;
  end
endmodule

// File: rtl/pf_thermal_latch.sv
module pf_thermal_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ot_in,
  input  logic rd_hit,
  output logic tsd_flag
);
  logic tsd_q, tsd_d;

  always_comb begin
    tsd_d = tsd_q;
    if (ot_in)       tsd_d = 1'b1;
    else if (rd_hit) tsd_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tsd_q <= 1'b0;
    else        tsd_q <= tsd_d;
  end

  assign tsd_flag = tsd_q;
endmodule

// File: rtl/pf_chan_ctrl.sv
module pf_chan_ctrl #(
  parameter int SETTLE_CYC = 20,
  parameter int CNT_W      = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_bit,
  input  logic rd_hit,
  input  logic ld_req,
  input  logic clamp_en,
  input  logic oc_in,
  input  logic ot_in,
  output logic pu,
  output logic busy,
  output logic ld_pulse,
  output logic oc_alert
);
  localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(SETTLE_CYC);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic             pu_q, pu_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             pend_q, pend_d;
  logic             fire_q, fire_d;
  logic             alert_q, alert_d;
  logic             want;

  always_comb begin
    // enable: overtemperature > unclamped overcurrent > software write
    pu_d = pu_q;
    if (ot_in)                   pu_d = 1'b0;
    else if (oc_in && !clamp_en) pu_d = 1'b0;
    else if (wr_hit)             pu_d = wr_bit;

    // settling window counter, clock-enabled
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!pu_d) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (!pu_q) begin
      cnt_en = 1'b1;
      cnt_d  = WIN_LOAD;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - ONE;
    end

    // load: fires when the window ends on this edge, else waits
    want   = pu_q & pu_d & (ld_req | pend_q);
    fire_d = want & (cnt_q <= ONE);
    pend_d = want & (cnt_q >  ONE);

    alert_d = oc_in | (alert_q & ~rd_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pu_q    <= 1'b0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      fire_q  <= 1'b0;
      alert_q <= 1'b0;
    end else begin
      pu_q    <= pu_d;
      if (cnt_en) cnt_q <= cnt_d;
      pend_q  <= pend_d;
      fire_q  <= fire_d;
      alert_q <= alert_d;
    end
  end

  assign pu       = pu_q;
  assign busy     = (cnt_q != '0);
  assign ld_pulse = fire_q;
  assign oc_alert = alert_q;
endmodule

// File: rtl/dac_pwr_fault_reg.sv
module dac_pwr_fault_reg
  import dac_pf_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 2_000_000,
  parameter int SETTLE_US   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        reg_sel,
  input  logic [NCH-1:0]    wr_pu,
  input  logic              ld_req,
  input  logic              clamp_en,
  input  logic [NCH-1:0]    oc_in,
  input  logic              ot_in,
  output logic [NCH-1:0]    pwr_on,
  output logic [NCH-1:0]    ld_out,
  output logic [STAT_W-1:0] rd_data
);
  localparam int RAW_CYC    = (CLK_FREQ_HZ / 1_000_000) * SETTLE_US;
  localparam int SETTLE_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;
  localparam int CNT_W      = $clog2(SETTLE_CYC + 1);

  logic              rst_s;
  logic              wr_hit, rd_hit;
  logic              tsd_flag;
  logic [NCH-1:0]    busy;
  logic [NCH-1:0]    oc_alert;
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] rd_q;

  pf_reset_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_s)
  );

  pf_access_decode u_dec (
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .reg_sel(reg_sel),
    .wr_hit (wr_hit),
    .rd_hit (rd_hit)
  );

  pf_thermal_latch u_therm (
    .clk     (clk),
    .rst_n   (rst_s),
    .ot_in   (ot_in),
    .rd_hit  (rd_hit),
    .tsd_flag(tsd_flag)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pf_chan_ctrl #(
      .SETTLE_CYC(SETTLE_CYC),
      .CNT_W     (CNT_W)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_s),
      .wr_hit  (wr_hit),
      .wr_bit  (wr_pu[ch]),
      .rd_hit  (rd_hit),
      .ld_req  (ld_req),
      .clamp_en(clamp_en),
      .oc_in   (oc_in[ch]),
      .ot_in   (ot_in),
      .pu      (pwr_on[ch]),
      .busy    (busy[ch]),
      .ld_pulse(ld_out[ch]),
      .oc_alert(oc_alert[ch])
    );
  end

  always_comb status = pack_status(pwr_on, tsd_flag, oc_alert);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      rd_q <= '0;
    else if (rd_hit) rd_q <= status;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_s,
  input logic           clamp_en,
  input logic           ot_in,
  input logic [NCH-1:0] oc_in,
  input logic           rd_hit,
  input logic [NCH-1:0] pwr_on,
  input logic [NCH-1:0] ld_out,
  input logic [NCH-1:0] busy,
  input logic [NCH-1:0] oc_alert,
  input logic           tsd_flag
);
  assert_rise_starts_window_R4: assert property (@(posedge clk) disable iff (!rst_s)
    ((pwr_on & ~$past(pwr_on) & ~busy) == '0));

  assert_no_load_in_window_R4: assert property (@(posedge clk) disable iff (!rst_s)
    ((ld_out & busy) == '0));

  assert_load_only_powered_R5: assert property (@(posedge clk) disable iff (!rst_s)
    ((ld_out & ~pwr_on) == '0));

  assert_oc_unclamped_off_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (!clamp_en && (oc_in != '0)) |=> ((pwr_on & $past(oc_in)) == '0));

  assert_oc_sets_alert_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (oc_in != '0) |=> ((oc_alert & $past(oc_in)) == $past(oc_in)));

  assert_ot_all_off_R8: assert property (@(posedge clk) disable iff (!rst_s)
    ot_in |=> (pwr_on == '0) && tsd_flag);

  assert_alert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(rd_hit) |-> ((($past(oc_alert)) & ~oc_alert) == '0));
endmodule

bind dac_pwr_fault_reg pf_checker #(.NCH(dac_pf_pkg::NCH)) u_pf_chk (
  .clk     (clk),
  .rst_s   (rst_s),
  .clamp_en(clamp_en),
  .ot_in   (ot_in),
  .oc_in   (oc_in),
  .rd_hit  (rd_hit),
  .pwr_on  (pwr_on),
  .ld_out  (ld_out),
  .busy    (busy),
  .oc_alert(oc_alert),
  .tsd_flag(tsd_flag)
);

// File: tb/tb_dac_pwr_fault_reg.sv
module tb_dac_pwr_fault_reg;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 20;  // 2 MHz * 10 us

  typedef struct packed {
    logic [2:0] sel;
    logic [3:0] wd;
    logic       clamp;
    logic [3:0] oc;
    logic       ot;
    logic [3:0] exp_pu;
  } vec_t;

  // one write cycle per entry, faults held for that cycle only
  localparam vec_t VEC [8] = '{
    '{3'b010, 4'hF, 1'b0, 4'h0, 1'b0, 4'hF},  // R2 write all on
    '{3'b011, 4'h0, 1'b0, 4'h0, 1'b0, 4'hF},  // R2 other code ignored
    '{3'b010, 4'h5, 1'b0, 4'h0, 1'b0, 4'h5},  // R2 mixed pattern
    '{3'b000, 4'h0, 1'b0, 4'h1, 1'b0, 4'h4},  // R6 oc A unclamped
    '{3'b000, 4'h0, 1'b1, 4'h4, 1'b0, 4'h4},  // R7 oc C clamped keeps
    '{3'b010, 4'hF, 1'b0, 4'h0, 1'b1, 4'h0},  // R8 ot beats write
    '{3'b010, 4'h3, 1'b0, 4'h0, 1'b0, 4'h3},  // R2 write after ot
    '{3'b010, 4'hF, 1'b0, 4'h8, 1'b0, 4'h7}   // R6 oc D beats write
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, ld_req, clamp_en, ot_in;
  logic [2:0]  reg_sel;
  logic [3:0]  wr_pu, oc_in;
  logic [3:0]  pwr_on, ld_out;
  logic [10:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_pwr_fault_reg #(.CLK_FREQ_HZ(2_000_000), .SETTLE_US(10)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wr_pu(wr_pu), .ld_req(ld_req), .clamp_en(clamp_en), .oc_in(oc_in),
    .ot_in(ot_in), .pwr_on(pwr_on), .ld_out(ld_out), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; ld_req = 0; oc_in = 0; ot_in = 0; reg_sel = 3'b000; wr_pu = 0;
  endtask

  task automatic do_reset();
    idle();
    clamp_en = 0;
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step(); step(); step();
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [3:0] d);
    wr_en = 1; reg_sel = sel; wr_pu = d;
    step();
    wr_en = 0; reg_sel = 3'b000;
  endtask

  task automatic reg_read(input logic [2:0] sel);
    rd_en = 1; reg_sel = sel;
    step();
    rd_en = 0; reg_sel = 3'b000;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int first;
    int seen;
    do_reset();
    // R1 reset state
    check("R1 pwr_on", 16'(pwr_on), 16'h0);
    check("R1 ld_out", 16'(ld_out), 16'h0);
    check("R1 rd_data", 16'(rd_data), 16'h0);

    // vector table
    for (int i = 0; i < 8; i++) begin
      wr_en = 1; reg_sel = VEC[i].sel; wr_pu = VEC[i].wd;
      clamp_en = VEC[i].clamp; oc_in = VEC[i].oc; ot_in = VEC[i].ot;
      step();
      idle();
      clamp_en = 0;
      check($sformatf("R2/R6/R7/R8 vec%0d pwr_on", i), 16'(pwr_on), 16'(VEC[i].exp_pu));
    end

    // R3 read with wrong code: no capture, no clear
    reg_read(3'b011);
    check("R3 wrong code rd_data", 16'(rd_data), 16'h0);
    // R3 status layout: oc D,C,A at 10,9,7; tsd at 5; pu 0111
    reg_read(3'b010);
    check("R3 status word", 16'(rd_data), 16'h06A7);
    // R9 inputs low -> cleared by that read
    reg_read(3'b010);
    check("R9 cleared after read", 16'(rd_data), 16'h0007);

    // R9 sticky while input held (B, clamped)
    clamp_en = 1; oc_in = 4'h2;
    step();
    reg_read(3'b010);
    check("R9 live alert read", 16'(rd_data & 11'h100), 16'h0100);
    reg_read(3'b010);
    check("R9 live alert kept", 16'(rd_data & 11'h100), 16'h0100);
    oc_in = 0;
    step();
    reg_read(3'b010);
    check("R9 released alert still shown", 16'(rd_data & 11'h100), 16'h0100);
    reg_read(3'b010);
    check("R9 released alert cleared", 16'(rd_data & 11'h100), 16'h0000);
    check("R7 clamped B stays on", 16'(pwr_on), 16'h0007);
    clamp_en = 0;

    // R8 writes ignored while ot held
    ot_in = 1;
    step();
    wr_en = 1; reg_sel = 3'b010; wr_pu = 4'hF;
    step();
    wr_en = 0; reg_sel = 3'b000;
    step();
    check("R8 write under ot", 16'(pwr_on), 16'h0);
    ot_in = 0;
    reg_read(3'b010);
    check("R8 tsd bit5", 16'(rd_data & 11'h020), 16'h0020);

    // R4 deferred load timing
    do_reset();
    reg_write(3'b010, 4'h1);   // edge E0
    ld_req = 1;
    step();                    // edge E1
    ld_req = 0;
    first = (ld_out[0] === 1'b1) ? 1 : 0;
    for (int k = 2; k <= WIN + 3; k++) begin
      step();
      if (ld_out[0] === 1'b1 && first == 0) first = k;
    end
    check("R4 deferred load edge", 16'(first), 16'(WIN));

    // R5 settled load and powered-down channels
    ld_req = 1;
    step();
    ld_req = 0;
    check("R5 settled load pulse", 16'(ld_out), 16'h1);
    step();
    check("R5 pulse one cycle", 16'(ld_out), 16'h0);
    reg_write(3'b010, 4'h0);
    ld_req = 1;
    step();
    ld_req = 0;
    check("R5 powered-down no pulse", 16'(ld_out), 16'h0);

    // R10 power-off cancels pending load
    reg_write(3'b010, 4'h2);
    ld_req = 1;
    step();
    ld_req = 0;
    reg_write(3'b010, 4'h0);
    seen = 0;
    for (int k = 0; k < WIN + 4; k++) begin
      step();
      if (ld_out !== 4'h0) seen++;
    end
    check("R10 cancelled load", 16'(seen), 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule